// File: doc/BRIEF.md
# Camera Byte-Pair Pixel Packer

This block sits on the pixel-clock side of a camera capture path. The camera delivers each 16-bit pixel as two bytes on consecutive accepted cycles over an 8-bit bus. The block joins every such pair into one word and offers it on a valid/ready write port that feeds a word queue. A single lane-select flip-flop sorts the bytes. The flip-flop inverts on each accepted byte, so it runs at half the byte rate. It also marks the cycle on which a finished word is sent. It returns to its first phase whenever the line strobe drops or the frame sync strobe is high, so a pair can never be made from bytes of two different lines.

Beside the data path, the block keeps a count of the words that the queue has taken since the last clear. A controller in another clock domain reads this count to decide when to drain the queue. That controller acknowledges a drain with a one-cycle pulse, which clears the count. The frame sync strobe also clears the count.

The camera cannot be stalled, so back-pressure can only drop data. A finished word is offered for exactly one cycle. If `word_ready` is low in that cycle, the word is lost and the count does not move. A queue that can be full must therefore raise its drain request early enough that `word_ready` stays high.

Top module: `pixel_pair_packer`

## Requirements
- R1: After reset, `word_valid` is 0 and `word_count` is 0.
- R2: A byte is accepted only on a clock edge where `line_act` is 1 and `frame_sync` is 0. On any other edge, `px_byte` has no effect on `word_valid`, `word_data` or later words.
- R3: Within a pair, the first accepted byte goes to `word_data[15:8]` and the second goes to `word_data[7:0]`. `word_valid` is high for the one cycle that follows the edge that accepted the second byte.
- R4: `word_valid` is never high on two consecutive cycles.
- R5: While `line_act` is 0 or `frame_sync` is 1, pairing restarts, so the next accepted byte is a high byte. A lone trailing byte of a line is discarded and never appears in any word.
- R6: A word is offered for one cycle only. If `word_ready` is 0 in that cycle, the word is dropped and `word_count` is unchanged.
- R7: Each cycle with `word_valid` and `word_ready` both 1 raises `word_count` by one on the next edge.
- R8: A `drain_ack` or `frame_sync` of 1 sets `word_count` to 0 on the next edge. If a handshake happens in the same cycle, the count is set to 1 instead.
- R9: `word_count` saturates at 2^CNT_W-1 and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| px_byte | input | BYTE_W | Camera data byte |
| line_act | input | 1 | Line strobe: bytes are valid while it is 1 |
| frame_sync | input | 1 | Frame sync strobe: restarts pairing and clears the count |
| drain_ack | input | 1 | One-cycle pulse from the drain controller that clears the count |
| word_valid | output | 1 | A finished pixel word is offered |
| word_ready | input | 1 | The queue takes the word offered in this cycle |
| word_data | output | 2*BYTE_W | Packed pixel, first byte in the upper half |
| word_count | output | CNT_W | Words taken since the last clear |

## Verification
The embedded assertions check on every cycle the properties that hold cycle by cycle:
- the lane phase returns to the high byte whenever a line ends or a frame starts;
- `word_valid` is one cycle wide and always follows an accepted byte;
- the count only holds, steps by one, or clears to the value that a concurrent handshake allows.

The directed scenarios are needed for the data-dependent behaviour:
- byte order inside a word;
- the loss of a lone trailing byte, and a clean restart on the next line;
- dropped words under back-pressure;
- saturation of the count.

// File: rtl/pxp_pkg.sv
package pxp_pkg;
  // Which half of the pixel word the next accepted byte fills.
  typedef enum logic {
    LANE_HI = 1'b0,
    LANE_LO = 1'b1
  } lane_e;
endpackage

// File: rtl/pxp_phase.sv
module pxp_phase
  import pxp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  take,
  input  logic  restart,
  output lane_e lane
);
  always_ff @(posedge clk) begin
    if (!rst_n)       lane <= LANE_HI;
    else if (restart) lane <= LANE_HI;
    else if (take)    lane <= (lane == LANE_HI) ? LANE_LO : LANE_HI;
  end

  // R5
  phase_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> lane == LANE_HI);
endmodule

// File: rtl/pxp_assemble.sv
module pxp_assemble
  import pxp_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  lane_e             lane,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              valid,
  output logic [WORD_W-1:0] data
);
  logic [BYTE_W-1:0] hi_q;
  logic              fire;

  assign fire = take && (lane == LANE_LO);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q  <= '0;
      valid <= 1'b0;
      data  <= '0;
    end else begin
      if (take && lane == LANE_HI) hi_q <= byte_in;
      valid <= fire;
      if (fire) data <= {hi_q, byte_in};
    end
  end

  // R4
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
  // R3
  valid_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $past(take));
endmodule

// File: rtl/pxp_fill_count.sv
module pxp_fill_count #(
  parameter int CNT_W = 12,
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hs,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)                     count <= '0;
    else if (clr)                   count <= hs ? CNT_W'(1) : '0;
    else if (hs && count != CNT_MAX) count <= count + 1'b1;
  end

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> count <= CNT_W'(1));
  // R7
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !clr && count != CNT_MAX) |=> count == $past(count) + 1'b1);
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hs && !clr) |=> $stable(count));
  // R9
  saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && count == CNT_MAX) |=> count == CNT_MAX);
endmodule

// File: rtl/pixel_pair_packer.sv
module pixel_pair_packer
  import pxp_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 12,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] px_byte,
  input  logic              line_act,
  input  logic              frame_sync,
  input  logic              drain_ack,
  output logic              word_valid,
  input  logic              word_ready,
  output logic [WORD_W-1:0] word_data,
  output logic [CNT_W-1:0]  word_count
);
  logic  take;
  logic  restart;
  lane_e lane;

  assign take    = line_act && !frame_sync;
  assign restart = !take;

  pxp_phase u_phase (
    .clk(clk), .rst_n(rst_n), .take(take), .restart(restart), .lane(lane)
  );

  pxp_assemble #(.BYTE_W(BYTE_W)) u_asm (
    .clk(clk), .rst_n(rst_n), .take(take), .lane(lane),
    .byte_in(px_byte), .valid(word_valid), .data(word_data)
  );

  pxp_fill_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .hs(word_valid && word_ready),
    .clr(drain_ack || frame_sync), .count(word_count)
  );

  // R2
  accept_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(line_act && !frame_sync));
endmodule

// File: tb/pixel_pair_packer_tb.sv
`timescale 1ns/1ps
module pixel_pair_packer_tb;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] px_byte = '0;
  logic line_act = 1'b0, frame_sync = 1'b0, drain_ack = 1'b0, word_ready = 1'b1;
  logic word_valid;
  logic [15:0] word_data;
  logic [CW-1:0] word_count;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pixel_pair_packer #(.BYTE_W(8), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .px_byte(px_byte), .line_act(line_act),
    .frame_sync(frame_sync), .drain_ack(drain_ack), .word_valid(word_valid),
    .word_ready(word_ready), .word_data(word_data), .word_count(word_count)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive for one cycle from a falling edge; returns at the next falling edge.
  task automatic drive(logic [7:0] b, logic act, logic fs = 1'b0);
    px_byte = b; line_act = act; frame_sync = fs;
    @(negedge clk);
  endtask

  task automatic clear_count();
    drain_ack = 1'b1; drive(8'h00, 1'b0); drain_ack = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 valid", word_valid, 0);
    check("R1 count", word_count, 0);
  endtask

  task automatic t_pair();
    drive(8'hA5, 1); drive(8'h3C, 1);
    check("R3 valid", word_valid, 1);
    check("R3 data", word_data, 16'hA53C);
    drive(8'h00, 0);
    check("R4 valid drops", word_valid, 0);
    check("R7 count", word_count, 1);
  endtask

  task automatic t_line();
    logic [7:0] b [6] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
    for (int i = 0; i < 6; i += 2) begin
      drive(b[i], 1);
      if (i > 0) check("R4 no back-to-back", word_valid, 0);
      drive(b[i+1], 1);
      check("R3 line word", word_data, {b[i], b[i+1]});
    end
    drive(8'h00, 0);
    check("R7 count after line", word_count, 4);
  endtask

  task automatic t_lone_byte();
    drive(8'hEE, 1); drive(8'h00, 0); drive(8'h00, 0);
    check("R5 lone byte no word", word_valid, 0);
    drive(8'h12, 1); drive(8'h34, 1);
    check("R5 fresh pair", word_data, 16'h1234);
    drive(8'h00, 0);
  endtask

  task automatic t_ignored();
    drive(8'h77, 0); drive(8'h88, 0); drive(8'h99, 0);
    check("R2 idle bytes ignored", word_valid, 0);
    drive(8'hAB, 1, 1); drive(8'hCD, 1, 1);
    check("R2 sync bytes ignored", word_valid, 0);
    drive(8'h56, 1); drive(8'h78, 1);
    check("R2 clean word", word_data, 16'h5678);
    drive(8'h00, 0);
  endtask

  task automatic t_drain();
    clear_count();
    check("R8 drain clears", word_count, 0);
    drive(8'h01, 1); drive(8'h02, 1);
    drain_ack = 1'b1; drive(8'h00, 0); drain_ack = 1'b0;
    check("R8 clear with handshake", word_count, 1);
    drive(8'h00, 0, 1);
    check("R8 frame sync clears", word_count, 0);
  endtask

  task automatic t_vsync_phase();
    drive(8'hF0, 1); drive(8'h00, 1, 1);
    drive(8'h9A, 1); drive(8'hBC, 1);
    check("R5 sync restarts phase", word_data, 16'h9ABC);
    drive(8'h00, 0);
  endtask

  task automatic t_backpressure();
    clear_count();
    drive(8'h10, 1); drive(8'h20, 1);
    word_ready = 1'b0; drive(8'h00, 0); word_ready = 1'b1;
    check("R6 dropped word", word_count, 0);
    check("R6 not reoffered", word_valid, 0);
  endtask

  task automatic t_saturate();
    clear_count();
    for (int i = 0; i < 20; i++) begin
      drive(8'(i), 1); drive(8'(i + 1), 1);
    end
    drive(8'h00, 0);
    check("R9 saturation", word_count, 15);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pair();
    t_line();
    t_lone_byte();
    t_ignored();
    t_drain();
    t_vsync_phase();
    t_backpressure();
    t_saturate();
    finish_run();
  end
endmodule